// File: doc/BRIEF.md
# Configurable Dual-Mode Macrocell Register

A single storage cell for a programmable logic block. Configuration inputs make it a D flip-flop, a toggle (T) flip-flop, a transparent latch or a plain combinational pass-through. The clock or latch enable is taken from a set of clocks shared across the block, or from a private product-term clock. The cell is forced to 0 or 1 by initialisation terms that act at once, without waiting for a clock.

Two modes decide where the clock and the initialisation terms come from. Synchronous mode clocks the cell from any one of the block clocks. It clears and sets the cell from a reset term and a preset term that all cells of the block share. Asynchronous mode clocks the cell from its own product-term clock, or from block clock 0 or 1. A single private term initialises the cell, and a configuration bit decides whether that term clears or sets it. A swap bit exchanges the clear and set roles in both modes, and it also changes the value the cell takes at power-up.

Top module: `mcell_reg`

## Requirements
- R1: With kind_i=00 (D register), q_o takes d_i on the active edge of the selected clock. The active edge is the rising edge, or the falling edge when clk_inv_i=1.
- R2: With kind_i=01 (T register), d_i=1 inverts q_o on each active edge and d_i=0 holds q_o.
- R3: With kind_i=10 (latch), q_o follows d_i while the selected enable is high (or low when clk_inv_i=1), and q_o holds its value while the enable is inactive.
- R4: With kind_i=11 (bypass), q_o equals d_i at all times in either mode, whatever the clocks and initialisation terms do.
- R5: In synchronous mode (async_mode_i=0), clk_sel_i=n picks blk_clk_i[n], and the other block clocks have no effect.
- R6: In asynchronous mode, clk_sel_i of 00 or 01 picks ind_clk_i, 10 picks blk_clk_i[0] and 11 picks blk_clk_i[1]. A clock that is not picked has no effect.
- R7: In synchronous mode with swap_i=0, blk_rst_i forces q_o to 0 and blk_set_i forces q_o to 1, at once and without a clock. ind_init_i has no effect in this mode.
- R8: When the clear term and the set term are both active, q_o is 0.
- R9: In asynchronous mode, ind_init_i clears q_o when init_as_set_i=0 and sets q_o when init_as_set_i=1, at once. blk_rst_i and blk_set_i have no effect in this mode.
- R10: swap_i=1 exchanges the roles: in synchronous mode blk_rst_i sets and blk_set_i clears, and in asynchronous mode ind_init_i takes the opposite role from the one init_as_set_i names.
- R11: While rst_ni is low, a storing kind outputs 1 if the effective initialisation role is set, and 0 otherwise. The effective role is set when swap_i=1 in synchronous mode, and when init_as_set_i XOR swap_i is 1 in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Power-up pulse, active low |
| blk_clk_i | input | 4 | Clocks shared by the block |
| ind_clk_i | input | 1 | Private product-term clock |
| d_i | input | 1 | Data or toggle term |
| blk_rst_i | input | 1 | Shared clear term |
| blk_set_i | input | 1 | Shared set term |
| ind_init_i | input | 1 | Private initialisation term |
| async_mode_i | input | 1 | 0 synchronous mode, 1 asynchronous mode |
| kind_i | input | 2 | 00 D, 01 T, 10 latch, 11 bypass |
| clk_sel_i | input | 2 | Clock / enable select |
| clk_inv_i | input | 1 | Invert clock edge or enable level |
| init_as_set_i | input | 1 | Private term sets rather than clears |
| swap_i | input | 1 | Exchange the clear and set roles |
| q_o | output | 1 | Cell output |

## Verification
The bench asserts the clear and set terms in both orders. A design that lets the later term win would show 1 where 0 is due. It also drives each clock the mode does not pick, and it drives the shared terms in asynchronous mode, where a wrong clock or term mux would change q_o. The power-up value is checked under each mode and swap combination, because a design that ignored the swap for power-up would start with the wrong value. The inverted edge and the inverted latch level are also exercised; a design that dropped the inversion would capture half a cycle off, or would hold data when it should pass it.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [1:0] {
    K_DREG  = 2'b00,
    K_TREG  = 2'b01,
    K_LATCH = 2'b10,
    K_COMB  = 2'b11
  } store_kind_e;
endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
  parameter int NUM_BLK_CLK = 4,
  parameter int SEL_W       = $clog2(NUM_BLK_CLK)
) (
  input  logic [NUM_BLK_CLK-1:0] blk_clk_i,
  input  logic                   ind_clk_i,
  input  logic                   async_mode_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic                   inv_i,
  output logic                   clk_o
);
  logic [SEL_W-1:0] alt_idx;
  logic             raw;

  assign alt_idx = SEL_W'(sel_i[0]);

  always_comb begin
    if (!async_mode_i)            raw = blk_clk_i[sel_i];
    else if (!sel_i[SEL_W-1])     raw = ind_clk_i;
    else                          raw = blk_clk_i[alt_idx];
    clk_o = raw ^ inv_i;
  end
endmodule

// File: rtl/mcell_init_ctl.sv
module mcell_init_ctl (
  input  logic async_mode_i,
  input  logic swap_i,
  input  logic init_as_set_i,
  input  logic blk_rst_i,
  input  logic blk_set_i,
  input  logic ind_init_i,
  output logic ar_o,
  output logic ap_o,
  output logic pwr_set_o
);
  logic role_set;

  always_comb begin
    role_set = init_as_set_i ^ swap_i;
    if (async_mode_i) begin
      ar_o      = ind_init_i & ~role_set;
      ap_o      = ind_init_i &  role_set;
      pwr_set_o = role_set;
    end else begin
      ar_o      = swap_i ? blk_set_i : blk_rst_i;
      ap_o      = swap_i ? blk_rst_i : blk_set_i;
      pwr_set_o = swap_i;
    end
  end
endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ar_i,
  input  logic        ap_i,
  input  logic        pwr_set_i,
  input  store_kind_e kind_i,
  input  logic        d_i,
  output logic        q_o
);
  logic ff_q;
  logic lat_q;

  // clear outranks set; both outrank the clock
  always_ff @(posedge clk_i or posedge ar_i or posedge ap_i or negedge rst_ni) begin
    if (!rst_ni)               ff_q <= pwr_set_i;
    else if (ar_i)             ff_q <= 1'b0;
    else if (ap_i)             ff_q <= 1'b1;
    else if (kind_i == K_TREG) ff_q <= ff_q ^ d_i;
    else                       ff_q <= d_i;
  end

  always_latch begin
    if (!rst_ni)    lat_q = pwr_set_i;
    else if (ar_i)  lat_q = 1'b0;
    else if (ap_i)  lat_q = 1'b1;
    else if (clk_i) lat_q = d_i;
  end

  always_comb begin
    case (kind_i)
      K_LATCH: q_o = lat_q;
      K_COMB:  q_o = d_i;
      default: q_o = ff_q;
    endcase
  end
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
#(
  parameter int NUM_BLK_CLK = 4,
  localparam int SEL_W      = $clog2(NUM_BLK_CLK)
) (
  input  logic                   rst_ni,
  input  logic [NUM_BLK_CLK-1:0] blk_clk_i,
  input  logic                   ind_clk_i,
  input  logic                   d_i,
  input  logic                   blk_rst_i,
  input  logic                   blk_set_i,
  input  logic                   ind_init_i,
  input  logic                   async_mode_i,
  input  logic [1:0]             kind_i,
  input  logic [SEL_W-1:0]       clk_sel_i,
  input  logic                   clk_inv_i,
  input  logic                   init_as_set_i,
  input  logic                   swap_i,
  output logic                   q_o
);
  logic clk_eff, ar, ap, pwr_set;

  mcell_clk_sel #(.NUM_BLK_CLK(NUM_BLK_CLK), .SEL_W(SEL_W)) u_clk (
    .blk_clk_i   (blk_clk_i),
    .ind_clk_i   (ind_clk_i),
    .async_mode_i(async_mode_i),
    .sel_i       (clk_sel_i),
    .inv_i       (clk_inv_i),
    .clk_o       (clk_eff)
  );

  mcell_init_ctl u_init (
    .async_mode_i (async_mode_i),
    .swap_i       (swap_i),
    .init_as_set_i(init_as_set_i),
    .blk_rst_i    (blk_rst_i),
    .blk_set_i    (blk_set_i),
    .ind_init_i   (ind_init_i),
    .ar_o         (ar),
    .ap_o         (ap),
    .pwr_set_o    (pwr_set)
  );

  mcell_store u_store (
    .clk_i    (clk_eff),
    .rst_ni   (rst_ni),
    .ar_i     (ar),
    .ap_i     (ap),
    .pwr_set_i(pwr_set),
    .kind_i   (store_kind_e'(kind_i)),
    .d_i      (d_i),
    .q_o      (q_o)
  );
endmodule

// File: rtl/mcell_reg_chk.sv
module mcell_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       async_mode_i,
  input logic       swap_i,
  input logic       init_as_set_i,
  input logic [1:0] kind_i,
  input logic       blk_rst_i,
  input logic       blk_set_i,
  input logic       ind_init_i,
  input logic       d_i,
  input logic       q_o
);
  p_blk_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_mode_i && !swap_i && kind_i != 2'b11 && blk_rst_i) |-> (q_o == 1'b0));

  p_clear_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_mode_i && kind_i != 2'b11 && blk_rst_i && blk_set_i) |-> (q_o == 1'b0));

  p_blk_preset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_mode_i && !swap_i && kind_i != 2'b11 && !blk_rst_i && blk_set_i) |-> (q_o == 1'b1));

  p_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b11) |-> (q_o == d_i));

  p_swapped_set_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_mode_i && swap_i && kind_i != 2'b11 && blk_set_i) |-> (q_o == 1'b0));

  p_ind_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_mode_i && !(init_as_set_i ^ swap_i) && kind_i != 2'b11 && ind_init_i) |-> (q_o == 1'b0));
endmodule

bind mcell_reg mcell_reg_chk u_chk (
  .clk_i        (blk_clk_i[0]),
  .rst_ni       (rst_ni),
  .async_mode_i (async_mode_i),
  .swap_i       (swap_i),
  .init_as_set_i(init_as_set_i),
  .kind_i       (kind_i),
  .blk_rst_i    (blk_rst_i),
  .blk_set_i    (blk_set_i),
  .ind_init_i   (ind_init_i),
  .d_i          (d_i),
  .q_o          (q_o)
);

// File: tb/mcell_reg_test.sv
`timescale 1ns/1ps
module mcell_reg_test;
  logic       clk = 1'b0;
  logic [3:1] man = '0;
  logic       rst_n = 1'b1, ind_clk = 0, d = 0, brst = 0, bset = 0, ind_init = 0;
  logic       am = 0, inv = 0, as_set = 0, sw = 0;
  logic [1:0] kind = 0, sel = 0;
  logic       q;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  mcell_reg uut (
    .rst_ni(rst_n), .blk_clk_i({man, clk}), .ind_clk_i(ind_clk), .d_i(d),
    .blk_rst_i(brst), .blk_set_i(bset), .ind_init_i(ind_init),
    .async_mode_i(am), .kind_i(kind), .clk_sel_i(sel), .clk_inv_i(inv),
    .init_as_set_i(as_set), .swap_i(sw), .q_o(q)
  );

  task automatic check(input string tag, input logic exp);
    total++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q_o=%b expected %b at %0t", tag, q, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse(input int idx);
    man[idx] = 1'b1; #0.5; man[idx] = 1'b0; #0.5;
  endtask

  task automatic pulse_ind();
    ind_clk = 1'b1; #0.5; ind_clk = 1'b0; #0.5;
  endtask

  // configure, apply power-up pulse, check R11 value, release
  task automatic setup(input logic m, input logic [1:0] k, input logic [1:0] s,
                       input logic i, input logic a, input logic w);
    step();
    d = 0; brst = 0; bset = 0; ind_init = 0; ind_clk = 0; man = '0;
    am = m; kind = k; sel = s; inv = i; as_set = a; sw = w;
    #0.5 rst_n = 1'b0;
    #0.5 if (k != 2'b11) check("R11 power-up", m ? (a ^ w) : w);
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_dreg();
    setup(0, 2'b00, 2'd0, 0, 0, 0);
    d = 1; step(); check("R1 capture 1", 1);
    d = 0; step(); check("R1 capture 0", 0);
    setup(0, 2'b00, 2'd0, 1, 0, 0);
    d = 1; @(posedge clk); #1; check("R1 inverted, rising ignored", 0);
    step(); check("R1 inverted, falling captures", 1);
  endtask

  task automatic t_sel();
    setup(0, 2'b00, 2'd2, 0, 0, 0);
    d = 1; step(); step(); check("R5 blk0 unselected", 0);
    pulse(1); pulse(3); check("R5 blk1/blk3 unselected", 0);
    pulse(2); check("R5 blk2 selected", 1);
  endtask

  task automatic t_treg();
    setup(0, 2'b01, 2'd0, 0, 0, 0);
    d = 1; step(); check("R2 toggle to 1", 1);
    step(); check("R2 toggle to 0", 0);
    step(); check("R2 toggle to 1 again", 1);
    d = 0; step(); check("R2 hold", 1);
    step(); check("R2 hold 2", 1);
  endtask

  task automatic t_latch();
    setup(0, 2'b10, 2'd1, 0, 0, 0);
    d = 1; #0.5 check("R3 closed", 0);
    man[1] = 1; #0.5 check("R3 open passes 1", 1);
    d = 0; #0.5 check("R3 open passes 0", 0);
    man[1] = 0; #0.5 d = 1; #0.5 check("R3 closed holds", 0);
    setup(0, 2'b10, 2'd1, 1, 0, 0);
    d = 1; #0.5 check("R3 low-active open", 1);
    man[1] = 1; #0.5 d = 0; #0.5 check("R3 low-active closed holds", 1);
  endtask

  task automatic t_comb();
    setup(1, 2'b11, 2'd0, 0, 0, 0);
    d = 1; #0.5 check("R4 follows 1", 1);
    ind_init = 1; #0.5 check("R4 init ignored", 1);
    d = 0; #0.5 check("R4 follows 0", 0);
    setup(0, 2'b11, 2'd0, 0, 0, 0);
    bset = 1; #0.5 check("R4 shared set ignored", 0);
    d = 1; brst = 1; #0.5 check("R4 shared clear ignored", 1);
  endtask

  task automatic t_async_clk();
    setup(1, 2'b00, 2'd0, 0, 0, 0);
    d = 1; step(); step(); check("R6 blk0 unselected", 0);
    pulse_ind(); check("R6 product-term clock", 1);
    setup(1, 2'b00, 2'd1, 1, 0, 0);
    d = 1; ind_clk = 1; #0.5 check("R6 inverted rise ignored", 0);
    ind_clk = 0; #0.5 check("R6 inverted fall captures", 1);
    setup(1, 2'b00, 2'd3, 0, 0, 0);
    d = 1; step(); check("R6 sel3 ignores blk0", 0);
    pulse(1); check("R6 sel3 uses blk1", 1);
    setup(1, 2'b00, 2'd2, 0, 0, 0);
    d = 1; pulse_ind(); check("R6 sel2 ignores pt clock", 0);
    step(); check("R6 sel2 uses blk0", 1);
  endtask

  task automatic t_sync_init();
    setup(0, 2'b00, 2'd0, 0, 0, 0);
    bset = 1; #0.5 check("R7 set immediate", 1);
    step(); check("R7 set held over clock", 1);
    bset = 0; step(); check("R7 clock after set", 0);
    d = 1; brst = 1; #0.5 check("R7 clear immediate", 0);
    step(); check("R7 clear held over clock", 0);
    brst = 0; step(); check("R7 clock after clear", 1);
    brst = 1; #0.5 bset = 1; #0.5 check("R8 set after clear", 0);
    brst = 0; bset = 0; step(); check("R8 release", 1);
    d = 0; step(); bset = 1; #0.5 check("R8 pre-set", 1);
    brst = 1; #0.5 check("R8 clear after set", 0);
    brst = 0; bset = 0; step();
    d = 1; step(); ind_init = 1; #0.5 check("R7 private term ignored", 1);
    ind_init = 0;
  endtask

  task automatic t_async_init();
    setup(1, 2'b00, 2'd2, 0, 0, 0);
    d = 1; step(); check("R9 load", 1);
    ind_init = 1; #0.5 check("R9 private clear", 0);
    step(); check("R9 clear held", 0);
    ind_init = 0; step(); check("R9 release", 1);
    brst = 1; #0.5 check("R9 shared clear ignored", 1);
    brst = 0; d = 0; step(); bset = 1; #0.5 check("R9 shared set ignored", 0);
    bset = 0;
    setup(1, 2'b00, 2'd2, 0, 1, 0);
    step(); check("R9 load 0", 0);
    ind_init = 1; #0.5 check("R9 private set", 1);
    ind_init = 0;
  endtask

  task automatic t_swap();
    setup(0, 2'b00, 2'd0, 0, 0, 1);
    step(); check("R10 load 0", 0);
    brst = 1; #0.5 check("R10 shared reset sets", 1);
    brst = 0; step(); d = 1; step(); check("R10 load 1", 1);
    bset = 1; #0.5 check("R10 shared set clears", 0);
    bset = 0;
    setup(1, 2'b00, 2'd2, 0, 0, 1);
    step(); check("R10 async load 0", 0);
    ind_init = 1; #0.5 check("R10 private clear becomes set", 1);
    ind_init = 0;
    setup(1, 2'b00, 2'd2, 0, 1, 1);
    d = 1; step(); check("R10 async load 1", 1);
    ind_init = 1; #0.5 check("R10 private set becomes clear", 0);
    ind_init = 0;
  endtask

  initial begin
    t_dreg();
    t_sel();
    t_treg();
    t_latch();
    t_comb();
    t_async_clk();
    t_sync_init();
    t_async_init();
    t_swap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    total++; fails++;
    $display("FAIL watchdog: q_o=%b expected completion", q);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule